// File: doc/BRIEF.md
# ADC Digital Test Pattern Generator

This block sits between a data converter's sampling core and its output formatter. On every sample clock it emits one 12-bit two's-complement word. With the mode code at zero, the live converter sample is forwarded. Any other mode code replaces that sample with a synthetic pattern, and the analog data is then ignored. The patterns are fixed codes, an alternating bit checkerboard, an all-ones/all-zeros toggle, a long and a short pseudo-random sequence, a four-word user sequence and a ramp. A system bring-up flow uses them to test the digital link without an analog source.

The output is registered, so a mode applied before a clock edge shows at the output after that edge. Whenever the mode code changes, every sequenced pattern starts over from its first word on the next sample. Each pseudo-random generator also has its own hold-at-seed control. The user sequence reads the already-decoded 12-bit field of each user register. It either cycles through the four words or plays them once and then stays at zero.

Top module: `adc_test_pattern_gen`

## Requirements
- R1: With mode 4'h0 the output equals the `adc_data_i` value present before the same clock edge, one register of latency.
- R2: Modes 4'h1, 4'h2 and 4'h3 output 12'h000, 12'h7FF and 12'h800 respectively, on every sample.
- R3: Mode 4'h4 outputs 12'hAAA on its first sample after entry, then alternates 12'h555, 12'hAAA on each later sample.
- R4: Mode 4'h7 outputs 12'hFFF on its first sample after entry, then alternates 12'h000, 12'hFFF.
- R5: Mode 4'h5 runs a 23-bit shift register whose new bit 0 is state bit 22 XOR state bit 17, with the other bits shifting up one place (x^23 + x^18 + 1). The seed is 23'h003AFF. The first sample after entry is the low 12 bits of the seed (12'hAFF), and each later sample is the low 12 bits of the next state.
- R6: Mode 4'h6 runs a 9-bit shift register whose new bit 0 is state bit 8 XOR state bit 4 (x^9 + x^5 + 1). The seed is 9'h092. It outputs the state zero-extended to 12 bits and starts at 12'h092, stepping as in R5.
- R7: While `pn_long_rst_i` is high, mode 4'h5 outputs the seed word 12'hAFF, and after release the sequence continues from the seed. `pn_short_rst_i` does the same for mode 4'h6. Neither control affects the other generator.
- R8: Mode 4'h8 outputs `user_word0_i`, `user_word1_i`, `user_word2_i`, `user_word3_i` in that order, starting with word 0 on the first sample after entry.
- R9: With `repeat_i` high, the user sequence wraps from word 3 back to word 0.
- R10: With `repeat_i` low, the user sequence outputs 12'h000 after word 3 and holds it until the mode changes, even if `repeat_i` later rises.
- R11: Mode 4'hF outputs 0 on its first sample after entry and one more on each later sample, wrapping from 12'hFFF to 12'h000.
- R12: Mode codes 4'h9 to 4'hE output 12'h000. In every mode other than 4'h0 the value of `adc_data_i` has no effect on the output.
- R13: A change of mode code restarts the checkerboard, toggle, ramp, user and pseudo-random sequences at their first word on the next sample.
- R14: While `rst_n` is low, `sample_o` is 12'h000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronously released upstream |
| mode_i | input | 4 | Test mode code |
| repeat_i | input | 1 | User sequence: 1 repeats, 0 plays once |
| pn_long_rst_i | input | 1 | Hold the long pseudo-random generator at its seed |
| pn_short_rst_i | input | 1 | Hold the short pseudo-random generator at its seed |
| user_word0_i | input | 12 | User pattern word 0 |
| user_word1_i | input | 12 | User pattern word 1 |
| user_word2_i | input | 12 | User pattern word 2 |
| user_word3_i | input | 12 | User pattern word 3 |
| adc_data_i | input | 12 | Live converter sample |
| sample_o | output | 12 | Registered output sample |

## Verification
The bench builds the block with its defaults: a 12-bit sample, four user words, and the 23-bit and 9-bit generators. At 12 bits the ramp wraps after 4096 samples, so a single run can check the 12'hFFF to 12'h000 wrap at the port. At these widths the checkerboard words are exactly 12'hAAA and 12'h555. The bench computes both pseudo-random sequences from their polynomials and seeds, so it can compare dozens of words and the hold-at-seed behaviour against its own model.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [3:0] {
    TPG_OFF      = 4'h0,
    TPG_MID      = 4'h1,
    TPG_POS      = 4'h2,
    TPG_NEG      = 4'h3,
    TPG_CHECK    = 4'h4,
    TPG_PN_LONG  = 4'h5,
    TPG_PN_SHORT = 4'h6,
    TPG_TOGGLE   = 4'h7,
    TPG_USER     = 4'h8,
    TPG_RAMP     = 4'hF
  } tpg_mode_e;

  // Word with every odd bit set (1010... pattern from the MSB for even widths)
  function automatic logic [31:0] odd_bits(input int unsigned w);
    logic [31:0] v;
    v = '0;
    for (int unsigned i = 0; i < w; i++) begin
      v[i] = i[0];
    end
    return v;
  endfunction

endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
  parameter int unsigned LEN   = 23,
  parameter int unsigned TAP   = 18,
  parameter logic [LEN-1:0] SEED = LEN'(32'h3AFF),
  parameter int unsigned OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  output logic [OUT_W-1:0] word_o
);

  logic [LEN-1:0] state_q;
  logic [LEN-1:0] state_n;
  logic [LEN-1:0] base;
  logic           fb;

  // Load selects the seed for this sample; otherwise the held state is used
  always_comb begin
    base    = load_i ? SEED : state_q;
    fb      = base[LEN-1] ^ base[TAP-1];
    state_n = adv_i ? {base[LEN-2:0], fb} : base;
  end

  generate
    if (LEN >= OUT_W) begin : g_trunc
      assign word_o = base[OUT_W-1:0];
    end else begin : g_zext
      assign word_o = {{(OUT_W-LEN){1'b0}}, base};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else begin
      state_q <= state_n;
    end
  end

  // R5 and R6: a seeded maximal-length register never reaches the all-zero lock-up state
  p_lfsr_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R7: a held load pins the next state to one step past the seed in the active mode
  p_load_steps_seed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && adv_i) |=> state_q == {SEED[LEN-2:0], SEED[LEN-1] ^ SEED[TAP-1]});

endmodule

// File: rtl/tpg_seq_ctr.sv
module tpg_seq_ctr #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_n;

  always_comb begin
    cnt_o = restart_i ? '0 : cnt_q;
    cnt_n = cnt_q;
    if (en_i) begin
      cnt_n = cnt_o + 1'b1;
    end else if (restart_i) begin
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  // R11: one step per sample, wrapping modulo 2^W
  p_ramp_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !restart_i) |=> cnt_q == W'($past(cnt_q) + 1'b1));

  // R13: a restart in an active mode leaves the count just past zero
  p_ramp_restart_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && restart_i) |=> cnt_q == W'(1));

endmodule

// File: rtl/tpg_user_seq.sv
module tpg_user_seq #(
  parameter int unsigned W     = 12,
  parameter int unsigned N_PAT = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en_i,
  input  logic                        restart_i,
  input  logic                        repeat_i,
  input  logic [N_PAT-1:0][W-1:0]     pat_i,
  output logic [W-1:0]                word_o
);

  localparam int unsigned IDX_W = (N_PAT > 1) ? $clog2(N_PAT) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_PAT - 1);

  logic [IDX_W-1:0] idx_q, idx_n, idx_cur;
  logic             done_q, done_n, done_cur;

  always_comb begin
    idx_cur  = restart_i ? '0 : idx_q;
    done_cur = restart_i ? 1'b0 : done_q;
    word_o   = done_cur ? '0 : pat_i[idx_cur];
    idx_n    = idx_cur;
    done_n   = done_cur;
    if (en_i && !done_cur) begin
      if (idx_cur == LAST) begin
        idx_n = '0;
        if (!repeat_i) begin
          done_n = 1'b1;
        end
      end else begin
        idx_n = idx_cur + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      idx_q  <= idx_n;
      done_q <= done_n;
    end
  end

  // R10: once exhausted in single mode, the sequence stays exhausted until restart
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !restart_i) |=> done_q);

  // R8: words are visited in ascending order
  p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !restart_i && !done_q && idx_q != LAST) |=> idx_q == IDX_W'($past(idx_q) + 1'b1));

  // R9: repeat wraps from the last word to the first
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !restart_i && !done_q && idx_q == LAST && repeat_i) |=> (idx_q == '0 && !done_q));

endmodule

// File: rtl/adc_test_pattern_gen.sv
module adc_test_pattern_gen
  import tpg_pkg::*;
#(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned N_PAT     = 4,
  parameter int unsigned LONG_LEN  = 23,
  parameter int unsigned LONG_TAP  = 18,
  parameter logic [LONG_LEN-1:0] LONG_SEED = LONG_LEN'(32'h3AFF),
  parameter int unsigned SHORT_LEN = 9,
  parameter int unsigned SHORT_TAP = 5,
  parameter logic [SHORT_LEN-1:0] SHORT_SEED = SHORT_LEN'(32'h092)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode_i,
  input  logic              repeat_i,
  input  logic              pn_long_rst_i,
  input  logic              pn_short_rst_i,
  input  logic [DATA_W-1:0] user_word0_i,
  input  logic [DATA_W-1:0] user_word1_i,
  input  logic [DATA_W-1:0] user_word2_i,
  input  logic [DATA_W-1:0] user_word3_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic [DATA_W-1:0] sample_o
);

  localparam logic [DATA_W-1:0] W_MID   = '0;
  localparam logic [DATA_W-1:0] W_POS   = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] W_NEG   = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] W_CHK_A = DATA_W'(odd_bits(DATA_W));
  localparam logic [DATA_W-1:0] W_CHK_B = ~W_CHK_A;
  localparam logic [DATA_W-1:0] W_ONES  = '1;

  logic [3:0]        mode_q;
  logic              mode_chg;
  logic              ctr_en;
  logic [DATA_W-1:0] ctr_word;
  logic [DATA_W-1:0] pn_long_word;
  logic [DATA_W-1:0] pn_short_word;
  logic [DATA_W-1:0] user_word;
  logic [DATA_W-1:0] sample_n;
  logic [N_PAT-1:0][DATA_W-1:0] user_bank;

  // Gather the user words; unused slots beyond four read as zero
  generate
    for (genvar g = 0; g < N_PAT; g++) begin : g_bank
      if (g == 0) begin : g_w0
        assign user_bank[g] = user_word0_i;
      end else if (g == 1) begin : g_w1
        assign user_bank[g] = user_word1_i;
      end else if (g == 2) begin : g_w2
        assign user_bank[g] = user_word2_i;
      end else if (g == 3) begin : g_w3
        assign user_bank[g] = user_word3_i;
      end else begin : g_wz
        assign user_bank[g] = '0;
      end
    end
  endgenerate

  assign mode_chg = (mode_i != mode_q);
  assign ctr_en   = (mode_i == TPG_CHECK) || (mode_i == TPG_TOGGLE) || (mode_i == TPG_RAMP);

  tpg_seq_ctr #(
    .W (DATA_W)
  ) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (ctr_en),
    .restart_i (mode_chg),
    .cnt_o     (ctr_word)
  );

  tpg_lfsr #(
    .LEN   (LONG_LEN),
    .TAP   (LONG_TAP),
    .SEED  (LONG_SEED),
    .OUT_W (DATA_W)
  ) u_pn_long (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (mode_chg || pn_long_rst_i),
    .adv_i  (mode_i == TPG_PN_LONG),
    .word_o (pn_long_word)
  );

  tpg_lfsr #(
    .LEN   (SHORT_LEN),
    .TAP   (SHORT_TAP),
    .SEED  (SHORT_SEED),
    .OUT_W (DATA_W)
  ) u_pn_short (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (mode_chg || pn_short_rst_i),
    .adv_i  (mode_i == TPG_PN_SHORT),
    .word_o (pn_short_word)
  );

  tpg_user_seq #(
    .W     (DATA_W),
    .N_PAT (N_PAT)
  ) u_user (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (mode_i == TPG_USER),
    .restart_i (mode_chg),
    .repeat_i  (repeat_i),
    .pat_i     (user_bank),
    .word_o    (user_word)
  );

  // Output selection; codes without a pattern give midscale
  always_comb begin
    case (mode_i)
      TPG_OFF:      sample_n = adc_data_i;
      TPG_MID:      sample_n = W_MID;
      TPG_POS:      sample_n = W_POS;
      TPG_NEG:      sample_n = W_NEG;
      TPG_CHECK:    sample_n = ctr_word[0] ? W_CHK_B : W_CHK_A;
      TPG_TOGGLE:   sample_n = ctr_word[0] ? W_MID : W_ONES;
      TPG_PN_LONG:  sample_n = pn_long_word;
      TPG_PN_SHORT: sample_n = pn_short_word;
      TPG_USER:     sample_n = user_word;
      TPG_RAMP:     sample_n = ctr_word;
      default:      sample_n = W_MID;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= TPG_OFF;
      sample_o <= '0;
    end else begin
      mode_q   <= mode_i;
      sample_o <= sample_n;
    end
  end

  // R1: pass-through with one register of latency
  p_pass_through_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TPG_OFF) |=> sample_o == $past(adc_data_i));

  // R2: positive full scale is a clear sign bit over all-ones magnitude
  p_pos_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TPG_POS) |=> (!sample_o[DATA_W-1] && (&sample_o[DATA_W-2:0])));

  // R2: negative full scale has exactly one bit set
  p_neg_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TPG_NEG) |=> (sample_o[DATA_W-1] && $countones(sample_o) == 1));

  // R3: consecutive checkerboard samples are bitwise complements
  p_check_alt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TPG_CHECK && mode_q == TPG_CHECK) |=> sample_o == ~$past(sample_o));

  // R4: consecutive toggle samples are bitwise complements
  p_toggle_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TPG_TOGGLE && mode_q == TPG_TOGGLE) |=> sample_o == ~$past(sample_o));

  // R12: unassigned codes give midscale
  p_unlisted_mid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i >= 4'h9 && mode_i <= 4'hE) |=> sample_o == '0);

  // R13: entering the ramp starts it at zero
  p_ramp_entry_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == TPG_RAMP && mode_q != TPG_RAMP) |=> sample_o == '0);

endmodule

// File: tb/test_adc_test_pattern_gen.sv
module test_adc_test_pattern_gen;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  mode;
  logic        rep;
  logic        pnl_rst;
  logic        pns_rst;
  logic [11:0] uw0, uw1, uw2, uw3;
  logic [11:0] adc;
  logic [11:0] sample;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_test_pattern_gen i_adc_test_pattern_gen (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_i         (mode),
    .repeat_i       (rep),
    .pn_long_rst_i  (pnl_rst),
    .pn_short_rst_i (pns_rst),
    .user_word0_i   (uw0),
    .user_word1_i   (uw1),
    .user_word2_i   (uw2),
    .user_word3_i   (uw3),
    .adc_data_i     (adc),
    .sample_o       (sample)
  );

  // Vector fields: mode[35:32], adc[31:20], expected[19:8], requirement number[7:0]
  localparam logic [35:0] VEC [NVEC] = '{
    {4'h0, 12'h123, 12'h123, 8'd1},   // R1
    {4'h0, 12'hABC, 12'hABC, 8'd1},
    {4'h1, 12'h456, 12'h000, 8'd2},   // R2
    {4'h2, 12'h0F0, 12'h7FF, 8'd2},
    {4'h3, 12'hF0F, 12'h800, 8'd2},
    {4'h4, 12'h555, 12'hAAA, 8'd3},   // R3
    {4'h4, 12'hAAA, 12'h555, 8'd3},
    {4'h4, 12'h000, 12'hAAA, 8'd3},
    {4'h7, 12'h001, 12'hFFF, 8'd4},   // R4
    {4'h7, 12'hFFF, 12'h000, 8'd4},
    {4'h7, 12'h010, 12'hFFF, 8'd4},
    {4'h9, 12'h321, 12'h000, 8'd12},  // R12
    {4'hE, 12'h7FF, 12'h000, 8'd12},
    {4'hF, 12'h999, 12'h000, 8'd11},  // R11
    {4'hF, 12'h999, 12'h001, 8'd11},
    {4'hF, 12'h999, 12'h002, 8'd11},
    {4'h4, 12'h111, 12'hAAA, 8'd13},  // R13 restart after leaving checkerboard
    {4'hF, 12'h222, 12'h000, 8'd13},
    {4'hF, 12'h333, 12'h001, 8'd13},
    {4'h0, 12'h7E5, 12'h7E5, 8'd1}
  };

  function automatic logic [22:0] step_long(input logic [22:0] s);
    return {s[21:0], s[22] ^ s[17]};
  endfunction

  function automatic logic [8:0] step_short(input logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction

  task automatic check(input logic [11:0] exp, input string req);
    checks++;
    if (sample !== exp) begin
      errors++;
      $display("FAIL %s: sample_o=%03h expected=%03h at %0t", req, sample, exp, $time);
    end
  endtask

  // Apply inputs, wait one edge, sample just after it
  task automatic cycle(input logic [3:0] m);
    mode = m;
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [22:0] ls;
    logic [8:0]  ss;
    rst_n = 1'b0; mode = 4'h2; rep = 1'b1; pnl_rst = 1'b0; pns_rst = 1'b0;
    uw0 = 12'h123; uw1 = 12'hFED; uw2 = 12'h801; uw3 = 12'h7FE; adc = 12'h5A5;
    repeat (3) @(posedge clk);
    #1;
    check(12'h000, "R14");    // R14 reset value
    mode = 4'h0;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // Table walk: R1 R2 R3 R4 R11 R12 R13
    for (int i = 0; i < NVEC; i++) begin
      adc = VEC[i][31:20];
      cycle(VEC[i][35:32]);
      check(VEC[i][19:8], $sformatf("R%0d", VEC[i][7:0]));
    end

    // R5 long sequence from entry, ADC noise ignored (R12)
    ls = 23'h003AFF;
    for (int i = 0; i < 40; i++) begin
      adc = 12'(i * 37);
      cycle(4'h5);
      check(ls[11:0], "R5");
      ls = step_long(ls);
    end
    // R7 short control has no effect on the long generator
    pns_rst = 1'b1;
    for (int i = 0; i < 5; i++) begin
      cycle(4'h5);
      check(ls[11:0], "R7");
      ls = step_long(ls);
    end
    pns_rst = 1'b0;
    // R7 hold long generator at its seed, then continue from the seed
    pnl_rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cycle(4'h5);
      check(12'hAFF, "R7");
    end
    pnl_rst = 1'b0;
    ls = step_long(23'h003AFF);
    for (int i = 0; i < 6; i++) begin
      cycle(4'h5);
      check(ls[11:0], "R7");
      ls = step_long(ls);
    end

    // R6 short sequence, restarted from seed on entry (R13)
    ss = 9'h092;
    for (int i = 0; i < 30; i++) begin
      cycle(4'h6);
      check({3'b000, ss}, "R6");
      ss = step_short(ss);
    end
    pns_rst = 1'b1;
    cycle(4'h6);
    check(12'h092, "R7");
    pns_rst = 1'b0;
    ss = step_short(9'h092);
    for (int i = 0; i < 4; i++) begin
      cycle(4'h6);
      check({3'b000, ss}, "R7");
      ss = step_short(ss);
    end

    // R8 R9 user sequence in repeat mode
    rep = 1'b1;
    for (int i = 0; i < 9; i++) begin
      logic [11:0] e;
      case (i % 4)
        0: e = uw0;
        1: e = uw1;
        2: e = uw2;
        default: e = uw3;
      endcase
      cycle(4'h8);
      check(e, (i < 4) ? "R8" : "R9");
    end

    // R10 single mode: leave and re-enter to restart
    cycle(4'h0);
    rep = 1'b0;
    cycle(4'h8); check(uw0, "R10");
    cycle(4'h8); check(uw1, "R10");
    cycle(4'h8); check(uw2, "R10");
    cycle(4'h8); check(uw3, "R10");
    cycle(4'h8); check(12'h000, "R10");
    cycle(4'h8); check(12'h000, "R10");
    rep = 1'b1;
    cycle(4'h8); check(12'h000, "R10");
    cycle(4'h8); check(12'h000, "R10");
    // R13 re-entry restarts the user sequence
    cycle(4'h1);
    cycle(4'h8); check(uw0, "R13");

    // R11 ramp wrap across 4096 samples
    cycle(4'h0);
    for (int i = 0; i < 4100; i++) begin
      cycle(4'hF);
      if (i == 4095 || i == 4096 || i == 4099 || i == 100) begin
        check(12'(i), "R11");
      end
    end

    // R14 mid-run reset forces zero
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(12'h000, "R14");
    @(negedge clk);
    rst_n = 1'b1;
    mode = 4'h7;
    @(posedge clk);
    #1;
    check(12'hFFF, "R4");

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule